// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Writes

This block is a memory-mapped general-purpose I/O controller for 128 pins, organised as four banks of 32. Software reaches it over a simple 32-bit register port with separate read and write strobes. For every pin the controller keeps a stored output level, a direction bit and a driver-enable bit. It also samples the pad level through a two-stage synchronizer. The pad is modelled as three separate vectors: the sampled input, the value to drive, and the drive enable.

Output levels are changed through eight masked write registers, each covering 16 pins. The upper half of the written word selects which pins are left untouched, and the lower half carries the new levels. Software can therefore change any subset of a half-bank in one write, with no read-modify-write. A pad is driven only when both its direction bit and its enable bit are set. Every pin comes out of reset as an undriven input.

Top module: `gpio_banked`

## Requirements
- R1: While reset is asserted, and right after it, every output level, direction bit and enable bit is 0. padOut and padOe are all zero, and the control registers read back 0.
- R2: The masked write register at byte address 4*k (k = 0..7) covers pins 16k..16k+15. In a write to it, bit [16+j] is the mask for pin 16k+j and bit [j] is the new level. Mask 0 loads the level. Mask 1 keeps the old level.
- R3: A masked write to one half-bank leaves the outputs of every other pin unchanged.
- R4: A read of masked write register k returns the current output levels of pins 16k..16k+15 in [15:0] and zero in [31:16].
- R5: The input register of bank b is at 0x060 + 4*b, and its bit n is pin 32b+n, taken after two synchronizing flops. A level applied one edge before the read-strobe edge still returns the previous level. A level held for two edges before that edge is returned.
- R6: The direction register of bank b is at 0x204 + 0x40*b. Writes store all 32 bits and reads return them; bit set means output.
- R7: The driver-enable register of bank b is at 0x208 + 0x40*b. Writes store all 32 bits and reads return them.
- R8: padOe for a pin is 1 exactly when its direction bit and its enable bit are both 1. padOut carries the stored output level of every pin.
- R9: An address outside the mapped registers, including any address with bits [1:0] not zero, reads as zero. A write to it changes no register and no pad output.
- R10: Read data appears on regRdData in the cycle after the read strobe. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 12 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 32 | Read data, valid the cycle after the strobe |
| padIn | input | 128 | Sampled pad levels |
| padOut | output | 128 | Level to drive on each pad |
| padOe | output | 128 | Drive enable of each pad |

## Verification
The bench builds the block with its default of four banks and a 12-bit address. That is the full 128-pin map, so the last half-bank register (0x01C), the third bank's control registers and the highest input register (0x06C) can all be reached. The vector table covers partial masks, all-ones masks, alternating masks and unmapped or misaligned writes. Directed steps then measure the synchronizer delay edge by edge, combine direction and enable settings across banks, and apply reset in the middle of a run.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // register kind selected by the address decode
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_MASK = 3'd1,
    SRC_IN   = 3'd2,
    SRC_DIR  = 3'd3,
    SRC_OEN  = 3'd4
  } regSrc_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic    wrMask;
    logic    wrDir;
    logic    wrOen;
    logic    rdEn;
    regSrc_e rdSrc;
    logic [7:0] idx;
  } ctlStrobe_t;

  localparam int REG_W      = 32;
  localparam int BANK_W     = 32;
  localparam int HALF_W     = 16;
  localparam int IN_BASE    = 'h060;
  localparam int DIR_BASE   = 'h204;
  localparam int OEN_BASE   = 'h208;
  localparam int CTL_STRIDE = 'h040;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output ctlStrobe_t        strb
);

  localparam int NUM_HALVES = 2 * NUM_BANKS;

  regSrc_e    kind;
  logic [7:0] idx;
  int         av;
  int         dirOff;
  int         oenOff;

  always_comb begin
    av     = int'(regAddr);
    dirOff = av - DIR_BASE;
    oenOff = av - OEN_BASE;
    kind   = SRC_NONE;
    idx    = '0;
    if (regAddr[1:0] == 2'b00 && av < 4 * NUM_HALVES) begin
      kind = SRC_MASK;
      idx  = 8'(av / 4);
    end else if (regAddr[1:0] == 2'b00 && av >= IN_BASE && av < IN_BASE + 4 * NUM_BANKS) begin
      kind = SRC_IN;
      idx  = 8'((av - IN_BASE) / 4);
    end else if (av >= DIR_BASE && (dirOff % CTL_STRIDE) == 0 && (dirOff / CTL_STRIDE) < NUM_BANKS) begin
      kind = SRC_DIR;
      idx  = 8'(dirOff / CTL_STRIDE);
    end else if (av >= OEN_BASE && (oenOff % CTL_STRIDE) == 0 && (oenOff / CTL_STRIDE) < NUM_BANKS) begin
      kind = SRC_OEN;
      idx  = 8'(oenOff / CTL_STRIDE);
    end
  end

  always_comb begin
    strb        = '0;
    strb.idx    = idx;
    strb.wrMask = regWrEn && (kind == SRC_MASK);
    strb.wrDir  = regWrEn && (kind == SRC_DIR);
    strb.wrOen  = regWrEn && (kind == SRC_OEN);
    strb.rdEn   = regRdEn;
    strb.rdSrc  = regRdEn ? kind : SRC_NONE;
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    strb,
  input  logic [REG_W-1:0]              wrData,
  output logic [REG_W-1:0]              rdData,
  input  logic [NUM_BANKS*BANK_W-1:0]   padIn,
  output logic [NUM_BANKS*BANK_W-1:0]   padOut,
  output logic [NUM_BANKS*BANK_W-1:0]   padOe
);

  localparam int NUM_HALVES = 2 * NUM_BANKS;
  localparam int NUM_PINS   = NUM_BANKS * BANK_W;

  logic [HALF_W-1:0] outHalf [NUM_HALVES];
  logic [BANK_W-1:0] dirBank [NUM_BANKS];
  logic [BANK_W-1:0] oenBank [NUM_BANKS];
  logic [NUM_PINS-1:0] inMeta;
  logic [NUM_PINS-1:0] inSync;
  logic [REG_W-1:0]  rdMux;

  // masked half-bank output update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int h = 0; h < NUM_HALVES; h++) outHalf[h] <= '0;
    end else if (strb.wrMask) begin
      for (int h = 0; h < NUM_HALVES; h++) begin
        if (strb.idx == 8'(h)) begin
          outHalf[h] <= (outHalf[h] & wrData[REG_W-1:HALF_W])
                      | (wrData[HALF_W-1:0] & ~wrData[REG_W-1:HALF_W]);
        end
      end
    end
  end

  // per-bank direction and driver-enable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        dirBank[b] <= '0;
        oenBank[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strb.wrDir && strb.idx == 8'(b)) dirBank[b] <= wrData;
        if (strb.wrOen && strb.idx == 8'(b)) oenBank[b] <= wrData;
      end
    end
  end

  // two-flop input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inMeta <= '0;
      inSync <= '0;
    end else begin
      inMeta <= padIn;
      inSync <= inMeta;
    end
  end

  // read source select
  always_comb begin
    rdMux = '0;
    unique case (strb.rdSrc)
      SRC_MASK: begin
        for (int h = 0; h < NUM_HALVES; h++)
          if (strb.idx == 8'(h)) rdMux = {{(REG_W-HALF_W){1'b0}}, outHalf[h]};
      end
      SRC_IN: begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (strb.idx == 8'(b)) rdMux = inSync[b*BANK_W +: BANK_W];
      end
      SRC_DIR: begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (strb.idx == 8'(b)) rdMux = dirBank[b];
      end
      SRC_OEN: begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (strb.idx == 8'(b)) rdMux = oenBank[b];
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdMux;
  end

  // pad packing
  for (genvar h = 0; h < NUM_HALVES; h++) begin : gOutHalf
    assign padOut[h*HALF_W +: HALF_W] = outHalf[h];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gOeBank
    assign padOe[b*BANK_W +: BANK_W] = dirBank[b] & oenBank[b];
  end

endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWrEn,
  input  logic [31:0]                 regWrData,
  input  logic                        regRdEn,
  output logic [31:0]                 regRdData,
  input  logic [NUM_BANKS*32-1:0]     padIn,
  output logic [NUM_BANKS*32-1:0]     padOut,
  output logic [NUM_BANKS*32-1:0]     padOe
);

  ctlStrobe_t strb;

  gpio_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .regRdEn(regRdEn),
    .strb   (strb)
  );

  gpio_datapath #(
    .NUM_BANKS(NUM_BANKS)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(regWrData),
    .rdData(regRdData),
    .padIn (padIn),
    .padOut(padOut),
    .padOe (padOe)
  );

endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       regAddr,
  input logic                    regWrEn,
  input logic [31:0]             regWrData,
  input logic                    regRdEn,
  input logic [31:0]             regRdData,
  input logic [NUM_BANKS*32-1:0] padOut,
  input logic [NUM_BANKS*32-1:0] padOe
);

  localparam int NUM_HALVES = 2 * NUM_BANKS;
  localparam int NUM_PINS   = NUM_BANKS * 32;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (padOut == '0 && padOe == '0));

  // R9
  misaligned_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr[1:0] != 2'b00) |=> regRdData == '0);

  // R9
  non_mask_write_keeps_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && int'(regAddr) >= 4 * NUM_HALVES) |=> $stable(padOut));

  for (genvar h = 0; h < NUM_HALVES; h++) begin : gHalfChk
    localparam logic [NUM_PINS-1:0] OTHERS = ~({{(NUM_PINS-16){1'b0}}, 16'hFFFF} << (h*16));

    // R2
    masked_update_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == ADDR_W'(h*4)) |=>
        padOut[h*16 +: 16] == (($past(padOut[h*16 +: 16]) & $past(regWrData[31:16]))
                             | ($past(regWrData[15:0]) & ~$past(regWrData[31:16]))));

    // R3
    other_halves_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == ADDR_W'(h*4)) |=> ((padOut ^ $past(padOut)) & OTHERS) == '0);

    // R4
    mask_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regRdEn && regAddr == ADDR_W'(h*4)) |=>
        regRdData == {16'h0000, $past(padOut[h*16 +: 16])});
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBankChk
    // R8
    dir_clear_undrives_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == ADDR_W'('h204 + 'h40*b) && regWrData == '0) |=>
        padOe[b*32 +: 32] == '0);
  end

endmodule

bind gpio_banked gpio_banked_chk #(
  .NUM_BANKS(NUM_BANKS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdEn  (regRdEn),
  .regRdData(regRdData),
  .padOut   (padOut),
  .padOe    (padOe)
);

// File: tb/tb_gpio_banked.sv
module tb_gpio_banked;

  localparam int NUM_BANKS = 4;
  localparam int ADDR_W    = 12;
  localparam int NUM_PINS  = NUM_BANKS * 32;
  localparam int NV        = 24;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [ADDR_W-1:0]   regAddr = '0;
  logic                regWrEn = 1'b0;
  logic [31:0]         regWrData = '0;
  logic                regRdEn = 1'b0;
  logic [31:0]         regRdData;
  logic [NUM_PINS-1:0] padIn = '0;
  logic [NUM_PINS-1:0] padOut;
  logic [NUM_PINS-1:0] padOe;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  gpio_banked #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  // {isWrite, address, write data or expected read data, requirement}
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'h0000_A5A5, 8'd2},  // R2 full update of half 0
    {1'b0, 12'h000, 32'h0000_A5A5, 8'd4},  // R4 readback
    {1'b1, 12'h000, 32'hFF00_1234, 8'd2},  // R2 upper byte masked
    {1'b0, 12'h000, 32'h0000_A534, 8'd2},
    {1'b1, 12'h004, 32'h0000_FFFF, 8'd3},  // R3 write half 1
    {1'b0, 12'h000, 32'h0000_A534, 8'd3},  // half 0 untouched
    {1'b0, 12'h004, 32'h0000_FFFF, 8'd4},
    {1'b1, 12'h01C, 32'hFFFF_0000, 8'd2},  // R2 all masked
    {1'b0, 12'h01C, 32'h0000_0000, 8'd2},
    {1'b1, 12'h01C, 32'h0000_8001, 8'd2},
    {1'b0, 12'h01C, 32'h0000_8001, 8'd4},
    {1'b1, 12'h204, 32'hF0F0_F0F0, 8'd6},  // R6 bank 0 direction
    {1'b0, 12'h204, 32'hF0F0_F0F0, 8'd6},
    {1'b1, 12'h248, 32'h1234_5678, 8'd7},  // R7 bank 1 enable
    {1'b0, 12'h248, 32'h1234_5678, 8'd7},
    {1'b1, 12'h284, 32'hDEAD_BEEF, 8'd6},  // R6 bank 2 direction
    {1'b0, 12'h244, 32'h0000_0000, 8'd6},
    {1'b0, 12'h284, 32'hDEAD_BEEF, 8'd6},
    {1'b1, 12'h100, 32'hFFFF_FFFF, 8'd9},  // R9 unmapped write
    {1'b0, 12'h100, 32'h0000_0000, 8'd9},
    {1'b1, 12'h002, 32'h0000_0000, 8'd9},  // R9 misaligned write
    {1'b0, 12'h000, 32'h0000_A534, 8'd9},
    {1'b1, 12'h008, 32'h5555_AAAA, 8'd2},  // R2 alternating mask
    {1'b0, 12'h008, 32'h0000_AAAA, 8'd2}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, padOut[31:0], 32'h0, "padOut in reset");
    check(1, padOe[31:0], 32'h0, "padOe in reset");
    rstN = 1'b1;
    doRead(12'h204, rd);
    check(1, rd, 32'h0, "direction after reset");
    check(1, padOe[127:96], 32'h0, "padOe after reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][52]) doWrite(VEC[i][51:40], VEC[i][39:8]);
      else begin
        doRead(VEC[i][51:40], rd);
        check(int'(VEC[i][7:0]), rd, VEC[i][39:8], $sformatf("vector %0d", i));
      end
    end

    // R8: driven values and enables
    check(8, padOut[31:0], 32'hFFFF_A534, "padOut bank0");
    check(8, padOut[63:32], 32'h0000_AAAA, "padOut bank1");
    check(8, padOut[127:96], 32'h8001_0000, "padOut bank3");
    check(8, padOe[31:0], 32'h0, "dir without enable");
    check(8, padOe[63:32], 32'h0, "enable without dir");
    doWrite(12'h208, 32'hFF00_FF00);
    check(8, padOe[31:0], 32'hF000_F000, "bank0 both set");
    doRead(12'h208, rd);
    check(7, rd, 32'hFF00_FF00, "bank0 enable readback");
    doWrite(12'h288, 32'hFFFF_FFFF);
    check(8, padOe[95:64], 32'hDEAD_BEEF, "bank2 both set");
    doWrite(12'h284, 32'h0);
    check(6, padOe[95:64], 32'h0, "bank2 back to input");

    // R5: synchronizer depth and bit mapping
    @(negedge clk);
    padIn = {32'hCAFE_F00D, 32'h0, 32'h0, 32'h0000_0020};
    doRead(12'h06C, rd);
    check(5, rd, 32'h0, "one edge after change");
    doRead(12'h06C, rd);
    check(5, rd, 32'hCAFE_F00D, "bank3 synchronized");
    doRead(12'h060, rd);
    check(5, rd, 32'h0000_0020, "bank0 pin5");
    held = rd;

    // R10: read data holds between strobes
    repeat (4) @(negedge clk);
    check(10, regRdData, held, "hold without strobe");
    doRead(12'h061, rd);
    check(9, rd, 32'h0, "misaligned read");

    // R1: reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(1, padOut[31:0], 32'h0, "padOut after mid reset");
    check(1, padOe[31:0], 32'h0, "padOe after mid reset");
    rstN = 1'b1;

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule